// File: doc/BRIEF.md
# Second-Level Translation Directory-Pointer Stage

This block carries out one step of a second-level page walk, from guest-physical to host-physical, at the directory-pointer level. A request brings a guest-physical address, an access type, the base of the directory-pointer table and an enable for accessed/dirty tracking. The stage forms the address of one 64-bit entry, reads it through a request/response memory port and then classifies it.

There are four possible outcomes. A flag in the entry can make it a 1-GByte leaf, which ends the translation. Otherwise the entry points at a 4-KByte aligned next-level directory, and that base goes to the following stage. The stage can also report a permission violation or a misconfiguration. When tracking is enabled and the access succeeds, the stage writes the entry back with its accessed and dirty flags updated, but only if a flag actually changes.

All three data interfaces use valid/ready. The stage holds one request at a time: `req_ready` is high only while the stage is idle. Once `mem_req_valid` is raised, it stays high with its address, write flag and data unchanged until `mem_req_ready` is seen high. A result stays on `res_*` with `res_valid` high until `res_ready` accepts it. Read data has no back-pressure: `mem_rsp_valid` is a one-cycle strobe, and the stage accepts it only while it is waiting for data.

Top module: `s2w_dirptr_stage`

## Requirements
- R1: The entry read address is zero in bits 63:52, table base bits 51:12 in bits 51:12, guest-physical bits 38:30 in bits 11:3, and zero in bits 2:0.
- R2: Each request issues exactly one read (`mem_req_write`=0). While `mem_req_ready` is low, the read is held with a stable address and write flag.
- R3: An entry with bit 7 set is a leaf. On success `res_kind`=0 and `res_addr` = {12'b0, entry[51:30], gpa[29:0]}.
- R4: An entry with bit 7 clear points to the next level. On success `res_kind`=1 and `res_addr` = {12'b0, entry[51:12], 12'b0}.
- R5: `req_acc` 0 (read) needs entry bit 0, 1 (write) needs bit 1, 2 (fetch) needs bit 2, and code 3 acts as read. A missing grant gives `res_kind`=2.
- R6: An entry with bits 2:0 all zero gives `res_kind`=2 and no write-back, whatever the other bits hold.
- R7: A leaf entry with any nonzero bit in 29:12 or in 51:PA_W gives `res_kind`=3. This check takes priority over the permission check.
- R8: With `req_ad_en`=1 and a successful outcome, the write-back image sets bit 8, and also sets bit 9 for a write to a leaf. The entry is written to the same address only if the image differs from the entry read. With `req_ad_en`=0, or on any failure, nothing is written.
- R9: `res_sve` is entry bit 63 when `res_kind`=2 and is 0 for every other kind.
- R10: Entry bits 11:10 and 62:52 have no effect on `res_kind`, `res_addr` or `res_sve`.
- R11: After reset `req_ready`=1 while `res_valid` and `mem_req_valid` are 0. `req_ready` stays 0 from acceptance until the result is taken, and the result is held stable while `res_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Stage idle and able to take a request |
| req_gpa | input | 64 | Guest-physical address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_base | input | 64 | Table base; bits 51:12 are used |
| req_ad_en | input | 1 | Accessed/dirty tracking enable |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write-back, 0 for read |
| mem_req_addr | output | 64 | Entry address |
| mem_req_wdata | output | 64 | Write-back image |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read entry |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_kind | output | 2 | 0 leaf, 1 next level, 2 violation, 3 misconfiguration |
| res_addr | output | 64 | Host-physical address or next directory base |
| res_sve | output | 1 | Suppress-exception flag accompanying a violation |

## Verification
The read request appears in the cycle after the request handshake and holds until it is accepted. After the response strobe is captured, the stage spends one cycle evaluating the entry. The result or the write-back request appears in the cycle after that, and a write-back delays the result by one more cycle past its own acceptance. The bench drives stimulus and samples the ports on the falling edge. Because memory and result back-pressure are random, it does not count fixed cycles. It instead records each memory handshake and takes the result at the falling edge of the cycle in which `res_valid` and `res_ready` are both high, then compares what it recorded with values computed by its own functions.

// File: rtl/s2w_pkg.sv
package s2w_pkg;
  typedef enum logic [1:0] {
    KIND_LEAF   = 2'd0,
    KIND_NEXT   = 2'd1,
    KIND_VIOL   = 2'd2,
    KIND_MISCFG = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_EVAL, ST_WB, ST_DONE
  } st_e;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int ENT_W   = 64;
  localparam int TOP_PA  = 52;
  localparam int PAGE_LO = 12;
  localparam int GIG_LO  = 30;
  localparam int IDX_W   = 9;
  localparam int LEAF_B  = 7;
  localparam int ACC_B   = 8;
  localparam int DRT_B   = 9;
  localparam int SVE_B   = 63;
endpackage

// File: rtl/s2w_entry_addr.sv
module s2w_entry_addr
  import s2w_pkg::*;
(
  input  logic [ENT_W-1:0] base,
  input  logic [ENT_W-1:0] gpa,
  output logic [ENT_W-1:0] addr
);
  localparam int SLOT_LO = 3;

  always_comb begin
    addr = '0;
    addr[TOP_PA-1:PAGE_LO] = base[TOP_PA-1:PAGE_LO];
    addr[SLOT_LO +: IDX_W] = gpa[GIG_LO +: IDX_W];
  end
endmodule

// File: rtl/s2w_entry_eval.sv
module s2w_entry_eval
  import s2w_pkg::*;
#(
  parameter int PA_W = 46
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [ENT_W-1:0] gpa,
  input  logic [1:0]       acc,
  input  logic             ad_en,
  output logic [1:0]       kind,
  output logic [ENT_W-1:0] out_addr,
  output logic             sve,
  output logic             wb_need,
  output logic [ENT_W-1:0] wb_data
);
  localparam logic [ENT_W-1:0] ONE      = {{(ENT_W-1){1'b0}}, 1'b1};
  localparam logic [ENT_W-1:0] HIGH_RSV = ((ONE << TOP_PA) - ONE) & ~((ONE << PA_W) - ONE);
  localparam logic [ENT_W-1:0] MID_RSV  = ((ONE << GIG_LO) - ONE) & ~((ONE << PAGE_LO) - ONE);
  localparam logic [ENT_W-1:0] RSV_MASK = HIGH_RSV | MID_RSV;

  logic present, leaf, granted, bad_rsv, ok;

  always_comb begin
    present = |entry[2:0];
    leaf    = entry[LEAF_B];
    unique case (acc)
      ACC_WRITE: granted = entry[1];
      ACC_FETCH: granted = entry[2];
      default:   granted = entry[0];
    endcase
    bad_rsv = leaf && |(entry & RSV_MASK);

    if (!present)     kind = KIND_VIOL;
    else if (bad_rsv) kind = KIND_MISCFG;
    else if (!granted) kind = KIND_VIOL;
    else if (leaf)    kind = KIND_LEAF;
    else              kind = KIND_NEXT;

    ok = (kind == KIND_LEAF) || (kind == KIND_NEXT);

    out_addr = '0;
    if (leaf) begin
      out_addr[TOP_PA-1:GIG_LO] = entry[TOP_PA-1:GIG_LO];
      out_addr[GIG_LO-1:0]      = gpa[GIG_LO-1:0];
    end else begin
      out_addr[TOP_PA-1:PAGE_LO] = entry[TOP_PA-1:PAGE_LO];
    end
    if (!ok) out_addr = '0;

    sve = (kind == KIND_VIOL) && entry[SVE_B];

    wb_data = entry;
    wb_data[ACC_B] = 1'b1;
    if (leaf && acc == ACC_WRITE) wb_data[DRT_B] = 1'b1;
    wb_need = ad_en && ok && (wb_data != entry);
  end
endmodule

// File: rtl/s2w_dirptr_stage.sv
module s2w_dirptr_stage
  import s2w_pkg::*;
#(
  parameter int PA_W = 46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_gpa,
  input  logic [1:0]  req_acc,
  input  logic [63:0] req_base,
  input  logic        req_ad_en,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [63:0] mem_req_addr,
  output logic [63:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_kind,
  output logic [63:0] res_addr,
  output logic        res_sve
);
  st_e              st;
  logic [ENT_W-1:0] gpa_q, base_q, entry_q, addr_q, wdata_q;
  logic [1:0]       acc_q, kind_q;
  logic             ad_q, sve_q;

  logic [ENT_W-1:0] ent_addr, ev_addr, ev_wdata;
  logic [1:0]       ev_kind;
  logic             ev_sve, ev_wb;

  s2w_entry_addr u_addr (
    .base (base_q),
    .gpa  (gpa_q),
    .addr (ent_addr)
  );

  s2w_entry_eval #(.PA_W(PA_W)) u_eval (
    .entry    (entry_q),
    .gpa      (gpa_q),
    .acc      (acc_q),
    .ad_en    (ad_q),
    .kind     (ev_kind),
    .out_addr (ev_addr),
    .sve      (ev_sve),
    .wb_need  (ev_wb),
    .wb_data  (ev_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      gpa_q   <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      ad_q    <= 1'b0;
      entry_q <= '0;
      kind_q  <= KIND_LEAF;
      addr_q  <= '0;
      sve_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          gpa_q  <= req_gpa;
          base_q <= req_base;
          acc_q  <= req_acc;
          ad_q   <= req_ad_en;
          st     <= ST_RD;
        end
        ST_RD:   if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          entry_q <= mem_rsp_data;
          st      <= ST_EVAL;
        end
        ST_EVAL: begin
          kind_q  <= ev_kind;
          addr_q  <= ev_addr;
          sve_q   <= ev_sve;
          wdata_q <= ev_wdata;
          st      <= ev_wb ? ST_WB : ST_DONE;
        end
        ST_WB:   if (mem_req_ready) st <= ST_DONE;
        ST_DONE: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    mem_req_valid = (st == ST_RD) || (st == ST_WB);
    mem_req_write = (st == ST_WB);
    mem_req_addr  = ent_addr;
    mem_req_wdata = wdata_q;
    res_valid     = (st == ST_DONE);
    res_kind      = kind_q;
    res_addr      = addr_q;
    res_sve       = sve_q;
  end
endmodule

// File: rtl/s2w_dirptr_chk.sv
module s2w_dirptr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [63:0] mem_req_addr,
  input logic [63:0] mem_req_wdata,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_kind,
  input logic [63:0] res_addr,
  input logic        res_sve
);
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b0 && mem_req_addr[63:52] == 12'b0)); // R1

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R2

  AST_LEAF_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd0) |-> (res_addr[63:52] == 12'b0)); // R3

  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd1) |-> (res_addr[11:0] == 12'b0 && res_addr[63:52] == 12'b0)); // R4

  AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[8]); // R8

  AST_SVE_WITH_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != 2'd2) |-> !res_sve); // R9

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req_valid) |-> !req_ready); // R11

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_kind) && $stable(res_addr) && $stable(res_sve))); // R11
endmodule

bind s2w_dirptr_stage s2w_dirptr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_kind      (res_kind),
  .res_addr      (res_addr),
  .res_sve       (res_sve)
);

// File: tb/test_s2w_dirptr_stage.sv
module test_s2w_dirptr_stage;
  localparam int PA_W = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_gpa = '0;
  logic [1:0]  req_acc = '0;
  logic [63:0] req_base = '0;
  logic        req_ad_en = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_kind;
  logic [63:0] res_addr;
  logic        res_sve;

  always #4 clk = ~clk;

  s2w_dirptr_stage #(.PA_W(PA_W)) i_s2w_dirptr_stage (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model state
  logic [63:0] mem_entry = '0;
  int          rd_cnt, wr_cnt, lat;
  logic [63:0] rd_addr, wr_addr, wr_data;
  bit          busy_seen_low;
  bit          got_res;
  logic [1:0]  got_kind;
  logic [63:0] got_addr;
  logic        got_sve;
  bit          got_req_ready;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    // read data strobe
    mem_rsp_valid = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_entry;
      end
    end
    // memory request handshake (takes effect at next rising edge)
    mem_req_ready = ($urandom % 3) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_cnt++; wr_addr = mem_req_addr; wr_data = mem_req_wdata;
      end else begin
        rd_cnt++; rd_addr = mem_req_addr; lat = 1 + ($urandom % 3);
      end
    end
    if (rst_n && !req_ready && (mem_req_valid || res_valid || lat > 0)) busy_seen_low = 1'b1;
    res_ready = ($urandom % 2) != 0;
    if (rst_n && res_valid && res_ready && !got_res) begin
      got_res = 1'b1; got_kind = res_kind; got_addr = res_addr; got_sve = res_sve;
      got_req_ready = req_ready;
    end
  end

  function automatic logic [63:0] f_ent_addr(logic [63:0] base, logic [63:0] gpa);
    return {12'h0, base[51:12], gpa[38:30], 3'b000};
  endfunction

  function automatic void f_expect(input logic [63:0] e, input logic [63:0] gpa, input logic [1:0] acc,
                                   input bit ad, output logic [1:0] kind, output logic [63:0] addr,
                                   output bit sve, output bit wb, output logic [63:0] wdata);
    bit perm, rsv, good;
    logic [63:0] hmask;
    hmask = 64'h0;
    for (int b = PA_W; b < 52; b++) hmask[b] = 1'b1;
    perm = (acc == 2'd1) ? e[1] : (acc == 2'd2) ? e[2] : e[0];
    rsv  = e[7] && ((e[29:12] != 18'h0) || ((e & hmask) != 64'h0));
    if (e[2:0] == 3'b000) kind = 2'd2;
    else if (rsv) kind = 2'd3;
    else if (!perm) kind = 2'd2;
    else kind = e[7] ? 2'd0 : 2'd1;
    good = (kind < 2'd2);
    addr = !good ? 64'h0 : e[7] ? {12'h0, e[51:30], gpa[29:0]} : {12'h0, e[51:12], 12'h0};
    sve  = (kind == 2'd2) && e[63];
    wdata = e | 64'h100 | ((e[7] && acc == 2'd1) ? 64'h200 : 64'h0);
    wb = ad && good && (wdata != e);
  endfunction

  task automatic run(input logic [63:0] e, input logic [63:0] gpa, input logic [1:0] acc,
                     input logic [63:0] base, input bit ad);
    logic [1:0] ek; logic [63:0] ea, ew; bit es, ewb;
    string kt;
    f_expect(e, gpa, acc, ad, ek, ea, es, ewb, ew);
    mem_entry = e; rd_cnt = 0; wr_cnt = 0; got_res = 0; busy_seen_low = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_gpa = gpa; req_acc = acc; req_base = base; req_ad_en = ad;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_res) @(negedge clk);
    kt = (e[2:0] == 3'b0) ? "R6" : (ek == 2'd0) ? "R3" : (ek == 2'd1) ? "R4" : (ek == 2'd2) ? "R5" : "R7";
    chk(got_kind == ek, {kt, " kind"}, 64'(got_kind), 64'(ek));
    chk(got_addr == ea, {kt, " addr"}, got_addr, ea);
    chk(got_sve == es, "R9 sve", 64'(got_sve), 64'(es));
    chk(rd_cnt == 1, "R2 read count", 64'(rd_cnt), 64'd1);
    chk(rd_addr == f_ent_addr(base, gpa), "R1 entry address", rd_addr, f_ent_addr(base, gpa));
    chk(wr_cnt == (ewb ? 1 : 0), (e[2:0] == 3'b0) ? "R6 writeback count" : "R8 writeback count",
        64'(wr_cnt), 64'(ewb));
    if (ewb && wr_cnt == 1) begin
      chk(wr_data == ew, "R8 writeback data", wr_data, ew);
      chk(wr_addr == rd_addr, "R8 writeback address", wr_addr, rd_addr);
    end
    chk(!got_req_ready && busy_seen_low, "R11 busy", 64'(got_req_ready), 64'd0);
  endtask

  logic [63:0] base0 = 64'hFFF0_1234_5678_9ABC;
  logic [63:0] gpa0  = 64'h0000_7A5C_DEAD_BEEF;

  initial begin
    void'($urandom(32'd4242));
    lat = 0; rd_cnt = 0; wr_cnt = 0; got_res = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset req_ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0 && mem_req_valid == 1'b0, "R11 reset valids", 64'({res_valid, mem_req_valid}), 64'd0);
    rst_n = 1'b1;

    run(64'h0000_0012_C000_0087, gpa0, 2'd0, base0, 1'b0); // R3 leaf read
    run(64'h0000_0012_C000_0083, gpa0, 2'd1, base0, 1'b1); // R8 leaf write sets 8 and 9
    run(64'h0000_0012_C000_0383, gpa0, 2'd1, base0, 1'b1); // R8 flags already set: no write
    run(64'h0000_0012_C000_0283, gpa0, 2'd0, base0, 1'b0); // R8 disabled: no write
    run(64'h0000_0ABC_DEF0_1003, gpa0, 2'd1, base0, 1'b1); // R4 next level, bit 8 only
    run(64'h8000_0ABC_DEF0_1F78, gpa0, 2'd0, base0, 1'b1); // R6 not present
    run(64'h0000_4000_4000_0084, gpa0, 2'd0, base0, 1'b0); // R7 reserved + denied
    run(64'h0000_0000_4000_1087, gpa0, 2'd0, base0, 1'b0); // R7 mid reserved
    run(64'h8000_0001_4000_0083, gpa0, 2'd2, base0, 1'b0); // R5 R9 fetch denied
    run(64'h0000_0001_4000_0085, gpa0, 2'd3, base0, 1'b0); // R5 code 3 as read
    // R10: ignored bits give the same result as without them
    run(64'h0000_0012_C000_0087, gpa0, 2'd0, base0, 1'b0);
    begin
      logic [1:0] k0; logic [63:0] a0;
      k0 = got_kind; a0 = got_addr;
      run(64'h7FF0_0012_C000_0C87, gpa0, 2'd0, base0, 1'b0);
      chk(got_kind == k0 && got_addr == a0, "R10 ignored bits", got_addr, a0);
    end

    for (int i = 0; i < 400; i++) begin
      logic [63:0] e, g, b;
      e = {$urandom, $urandom};
      if (($urandom % 4) != 0) e[29:12] = '0;
      if (($urandom % 4) != 0) e[51:PA_W] = '0;
      if (($urandom % 8) == 0) e[2:0] = 3'b0;
      g = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run(e, g, 2'($urandom % 4), b, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule